// File: doc/BRIEF.md
# Indirect-addressed host register port

This block is the host-facing register port of an audio converter. A byte-wide bus with a 2-bit address reaches four places. Address 0 is an index pointer. Address 1 is a data window onto 16 indirect byte registers. Address 2 is a status byte. Address 3 is a shared programmed-I/O data port: writes feed playback and reads drain capture. The write and read strobes come from an asynchronous bus. They are synchronized into the core clock, and each strobe acts once, on its rising edge.

Sample traffic moves through two self-advancing byte pointers. A capture sample, handed in as a left and a right 16-bit word, is read out one byte per read. A playback sample is assembled one byte per write and handed to the converter side when the converter takes it. The status byte shows where each pointer stands. A sticky interrupt flag is set by a DMA count underflow and can gate the DMA request outputs. While an initialization-busy input is high, register writes are locked out and reads return a fixed busy code.

Top module: `hostreg_port`

## Requirements
- R1: Address 0 reads back {init_busy, mode-change bit, transfer-gate bit, 0, index[3:0]}. A write to address 0 stores index = data[3:0], transfer-gate = data[5] and mode-change = data[6]. Address 1 writes and reads the indirect register selected by the index.
- R2: After reset, address 0 reads 40h and address 2 reads CCh. The status bits are: bit0 interrupt, bit1 playback full, bit2 playback left (1 = left), bit3 playback upper (1 = upper), bit4 over/underrun, bit5 capture ready, bit6 capture left, bit7 capture upper.
- R3: While init_busy is high, writes to addresses 0, 1 and 3 have no effect. Reads of addresses 0, 1 and 3 return 80h and do not advance the capture pointer.
- R4: A dma_underflow pulse sets the interrupt bit. The bit stays set until any write to address 2 clears it, and a set in the same cycle wins over the clear.
- R5: Indirect register 9 bit0 enables playback requests and bit1 enables capture requests. play_req is high while playback is not full, and cap_req is high while capture is ready. While both the transfer-gate bit and the interrupt bit are 1, play_req, cap_req and cnt_dec_ok are low. Clearing either bit restores them.
- R6: Indirect register 8 bit0 selects stereo and bit1 selects 16-bit samples. In 16-bit stereo, capture reads return left-lower, left-upper, right-lower, right-upper in that order. After the last byte, capture-ready is 0 and further reads repeat the last byte.
- R7: Bytes that the format does not need are skipped. Mono leaves out the right bytes, and 8-bit leaves out the lower bytes, so the upper-byte status flags stay 1 in 8-bit formats.
- R8: A cap_valid pulse loads a new sample, moves the capture pointer back to the first byte and sets capture-ready.
- R9: Playback writes to address 3 fill the bytes in the same order as capture. Once the sample is full, the playback-full bit is 1 and further writes are ignored. A play_take pulse outputs the sample, with unused lower bytes as 0 and with right equal to left in mono, and then resets the pointer.
- R10: A play_take before the sample is full outputs zero on both channels. This underrun, or a cap_valid before the previous capture sample was fully read (an overrun), sets the over/underrun bit for that sample. The bit is recomputed at each cap_valid or play_take.
- R11: A strobe held high for many cycles acts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| init_busy | input | 1 | Initialization in progress; locks out writes |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Asynchronous write strobe, active high |
| host_rd | input | 1 | Asynchronous read strobe, active high |
| host_rdata | output | 8 | Byte captured on the last read |
| dma_underflow | input | 1 | DMA current-count underflow pulse |
| play_req | output | 1 | Playback DMA request |
| cap_req | output | 1 | Capture DMA request |
| cnt_dec_ok | output | 1 | DMA counter may decrement |
| cap_valid | input | 1 | New capture sample pulse |
| cap_left | input | 16 | Capture left word |
| cap_right | input | 16 | Capture right word |
| play_take | input | 1 | Converter takes the playback sample |
| play_left | output | 16 | Playback left word |
| play_right | output | 16 | Playback right word |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the stickiness and clearing of the interrupt flag, and request gating while both the gate and interrupt bits are set. They also cover the busy readback during initialization, the index holding still during lockout, zero output on a playback underrun, a pointer holding at its last byte, and a single action per strobe edge. Other behaviour shows only in the bench's scenarios. These are the exact byte order in each of the four formats, the status flags as the pointers advance, the pointer restart on a new sample, the assembly of the playback words, and the round trip of the indirect registers under random traffic.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  typedef enum logic [1:0] {
    A_INDEX = 2'd0,
    A_IDATA = 2'd1,
    A_STAT  = 2'd2,
    A_PIO   = 2'd3
  } addr_e;

  // byte slots: 0 left-lower, 1 left-upper, 2 right-lower, 3 right-upper
  function automatic logic [1:0] first_slot(input logic wide);
    return wide ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [1:0] last_slot(input logic stereo);
    return stereo ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [1:0] next_slot(input logic [1:0] p, input logic wide);
    case (p)
      2'd0:    return 2'd1;
      2'd1:    return wide ? 2'd2 : 2'd3;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/hostreg_edge.sv
module hostreg_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_in,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], a_in[i]};
    end
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/hostreg_byteseq.sv
module hostreg_byteseq
  import hostreg_pkg::*;
#(
  parameter bit RESET_DONE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       advance,
  input  logic       stereo,
  input  logic       wide,
  output logic [1:0] ptr,
  output logic       done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= 2'd1;
      done <= RESET_DONE;
    end else if (restart) begin
      ptr  <= first_slot(wide);
      done <= 1'b0;
    end else if (advance && !done) begin
      if (ptr == last_slot(stereo)) done <= 1'b1;
      else                          ptr  <= next_slot(ptr, wide);
    end
  end

  // R6
  hold_last_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !restart) |=> (done && $stable(ptr)));
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hostreg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int IW          = 4,
  parameter int SW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_busy,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          dma_underflow,
  output logic          play_req,
  output logic          cap_req,
  output logic          cnt_dec_ok,
  input  logic          cap_valid,
  input  logic [SW-1:0] cap_left,
  input  logic [SW-1:0] cap_right,
  input  logic          play_take,
  output logic [SW-1:0] play_left,
  output logic [SW-1:0] play_right
);
  localparam int NREG = 1 << IW;
  localparam logic [IW-1:0] FMT_IDX  = IW'(8);
  localparam logic [IW-1:0] XFER_IDX = IW'(9);
  localparam logic [DW-1:0] BUSY_BYTE = DW'(1) << (DW - 1);

  logic [1:0] rise;
  hostreg_edge #(.N(2), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .a_in({host_rd, host_wr}), .rise(rise));

  logic wr_act, rd_act;
  assign wr_act = rise[0];
  assign rd_act = rise[1];

  logic wr_idx, wr_data, wr_stat, wr_pio, rd_pio_adv;
  assign wr_idx     = wr_act && host_addr == A_INDEX && !init_busy;
  assign wr_data    = wr_act && host_addr == A_IDATA && !init_busy;
  assign wr_stat    = wr_act && host_addr == A_STAT;
  assign wr_pio     = wr_act && host_addr == A_PIO   && !init_busy;
  assign rd_pio_adv = rd_act && host_addr == A_PIO   && !init_busy;

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata[DW-1], host_wdata[4]};

  logic [IW-1:0] idx_q;
  logic trd_q, mce_q, int_q, sour_q;
  logic fmt_stereo, fmt_wide, play_en, cap_en;
  logic [DW-1:0] ram [NREG];
  logic [DW-1:0] ram_q;
  logic [SW-1:0] cap_l, cap_r;
  logic [DW-1:0] pbuf [4];

  logic [1:0] cptr, pptr;
  logic cap_done, play_done;

  hostreg_byteseq #(.RESET_DONE(1'b1)) u_capseq (
    .clk(clk), .rst(rst), .restart(cap_valid), .advance(rd_pio_adv),
    .stereo(fmt_stereo), .wide(fmt_wide), .ptr(cptr), .done(cap_done));

  hostreg_byteseq #(.RESET_DONE(1'b0)) u_playseq (
    .clk(clk), .rst(rst), .restart(play_take), .advance(wr_pio),
    .stereo(fmt_stereo), .wide(fmt_wide), .ptr(pptr), .done(play_done));

  // indirect register file, block-RAM style
  always_ff @(posedge clk) begin
    if (wr_data) ram[idx_q] <= host_wdata;
    ram_q <= ram[idx_q];
  end

  logic [DW-1:0] status, idx_view, data_view, cap_byte;
  assign status = {cptr[0], ~cptr[1], ~cap_done, sour_q,
                   pptr[0], ~pptr[1], play_done, int_q};
  assign idx_view = {init_busy, mce_q, trd_q, 1'b0, {(4-IW){1'b0}}, idx_q};

  always_comb begin
    if (idx_q == FMT_IDX)       data_view = {{(DW-2){1'b0}}, fmt_wide, fmt_stereo};
    else if (idx_q == XFER_IDX) data_view = {{(DW-2){1'b0}}, cap_en, play_en};
    else                        data_view = ram_q;
  end

  always_comb begin
    case (cptr)
      2'd0:    cap_byte = cap_l[DW-1:0];
      2'd1:    cap_byte = cap_l[SW-1:DW];
      2'd2:    cap_byte = cap_r[DW-1:0];
      default: cap_byte = cap_r[SW-1:DW];
    endcase
  end

  logic [SW-1:0] word_l, word_r;
  assign word_l = {pbuf[1], fmt_wide ? pbuf[0] : {DW{1'b0}}};
  assign word_r = fmt_stereo ? {pbuf[3], fmt_wide ? pbuf[2] : {DW{1'b0}}} : word_l;

  logic gate;
  assign gate = trd_q & int_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      trd_q      <= 1'b0;
      mce_q      <= 1'b1;
      int_q      <= 1'b0;
      sour_q     <= 1'b0;
      fmt_stereo <= 1'b0;
      fmt_wide   <= 1'b0;
      play_en    <= 1'b0;
      cap_en     <= 1'b0;
      cap_l      <= '0;
      cap_r      <= '0;
      play_left  <= '0;
      play_right <= '0;
      host_rdata <= '0;
      play_req   <= 1'b0;
      cap_req    <= 1'b0;
      cnt_dec_ok <= 1'b0;
      for (int i = 0; i < 4; i++) pbuf[i] <= '0;
    end else begin
      if (wr_idx) begin
        idx_q <= host_wdata[IW-1:0];
        trd_q <= host_wdata[5];
        mce_q <= host_wdata[6];
      end
      if (wr_data && idx_q == FMT_IDX) begin
        fmt_stereo <= host_wdata[0];
        fmt_wide   <= host_wdata[1];
      end
      if (wr_data && idx_q == XFER_IDX) begin
        play_en <= host_wdata[0];
        cap_en  <= host_wdata[1];
      end
      if (dma_underflow) int_q <= 1'b1;
      else if (wr_stat)  int_q <= 1'b0;

      if (cap_valid || play_take)
        sour_q <= (cap_valid & ~cap_done) | (play_take & ~play_done);

      if (cap_valid) begin
        cap_l <= cap_left;
        cap_r <= cap_right;
      end
      if (wr_pio && !play_done && !play_take) pbuf[pptr] <= host_wdata;
      if (play_take) begin
        play_left  <= play_done ? word_l : '0;
        play_right <= play_done ? word_r : '0;
      end

      if (rd_act) begin
        case (host_addr)
          A_INDEX: host_rdata <= init_busy ? BUSY_BYTE : idx_view;
          A_IDATA: host_rdata <= init_busy ? BUSY_BYTE : data_view;
          A_STAT:  host_rdata <= status;
          default: host_rdata <= init_busy ? BUSY_BYTE : cap_byte;
        endcase
      end

      play_req   <= play_en & ~play_done & ~gate;
      cap_req    <= cap_en & ~cap_done & ~gate;
      cnt_dec_ok <= ~gate;
    end
  end

  // R4
  int_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (int_q && !wr_stat) |=> int_q);
  // R4
  int_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !dma_underflow) |=> !int_q);
  // R5
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (trd_q && int_q) |=> (!play_req && !cap_req && !cnt_dec_ok));
  // R3
  init_read_chk: assert property (@(posedge clk) disable iff (rst)
    (init_busy && rd_act && host_addr != A_STAT) |=> host_rdata == BUSY_BYTE);
  // R3
  init_idx_chk: assert property (@(posedge clk) disable iff (rst)
    init_busy |=> $stable(idx_q));
  // R10
  underrun_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (play_take && !play_done) |=> (play_left == '0 && play_right == '0));
endmodule

// File: tb/tb_hostreg_port.sv
module tb_hostreg_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_busy = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic dma_underflow = 1'b0;
  logic play_req, cap_req, cnt_dec_ok;
  logic cap_valid = 1'b0;
  logic [15:0] cap_left = '0, cap_right = '0;
  logic play_take = 1'b0;
  logic [15:0] play_left, play_right;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hostreg_port dut (
    .clk(clk), .rst(rst), .init_busy(init_busy), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .dma_underflow(dma_underflow),
    .play_req(play_req), .cap_req(cap_req), .cnt_dec_ok(cnt_dec_ok),
    .cap_valid(cap_valid), .cap_left(cap_left), .cap_right(cap_right),
    .play_take(play_take), .play_left(play_left), .play_right(play_right));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d;
    repeat (2) @(negedge clk); host_wr = 1'b1;
    repeat (4) @(negedge clk); host_wr = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d, input int hold = 4);
    @(negedge clk); host_addr = a;
    repeat (2) @(negedge clk); host_rd = 1'b1;
    repeat (hold) @(negedge clk); host_rd = 1'b0;
    repeat (5) @(negedge clk);
    d = host_rdata;
  endtask

  task automatic pulse_cap(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk); cap_left = l; cap_right = r; cap_valid = 1'b1;
    @(negedge clk); cap_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_take();
    @(negedge clk); play_take = 1'b1;
    @(negedge clk); play_take = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_underflow();
    @(negedge clk); dma_underflow = 1'b1;
    @(negedge clk); dma_underflow = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_fmt(input logic stereo, input logic wide);
    bus_write(2'd0, 8'h08);
    bus_write(2'd1, {6'b0, wide, stereo});
  endtask

  function automatic int slot_count(input logic stereo, input logic wide);
    return (stereo ? 2 : 1) * (wide ? 2 : 1);
  endfunction

  // slot k of the read/write order, from the requirements
  function automatic int slot_at(input logic stereo, input logic wide, input int k);
    int chan = wide ? k / 2 : k;
    int upper = wide ? k % 2 : 1;
    return chan * 2 + upper;
  endfunction

  function automatic logic [7:0] byte_of(input logic [15:0] l, input logic [15:0] r, input int s);
    case (s)
      0: return l[7:0];
      1: return l[15:8];
      2: return r[7:0];
      default: return r[15:8];
    endcase
  endfunction

  logic [7:0] model [16];
  bit         mvalid [16];

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1848));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 reset values
    bus_read(2'd0, d); chk("R2 index reset", d, 8'h40);
    bus_read(2'd2, d); chk("R2 status reset", d, 8'hCC);

    // R1 index and indirect window
    bus_write(2'd0, 8'h43); bus_write(2'd1, 8'hA5);
    bus_write(2'd0, 8'h05); bus_write(2'd1, 8'h3C);
    bus_read(2'd0, d); chk("R1 index readback", d, 8'h05);
    bus_write(2'd0, 8'h03); bus_read(2'd1, d); chk("R1 reg3", d, 8'hA5);
    bus_write(2'd0, 8'h05); bus_read(2'd1, d); chk("R1 reg5", d, 8'h3C);

    // R3 init lockout
    init_busy = 1'b1;
    bus_read(2'd0, d); chk("R3 index busy", d, 8'h80);
    bus_read(2'd1, d); chk("R3 data busy", d, 8'h80);
    bus_read(2'd3, d); chk("R3 pio busy", d, 8'h80);
    bus_write(2'd0, 8'h27); bus_write(2'd1, 8'h99); bus_write(2'd3, 8'h77);
    init_busy = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(2'd0, d); chk("R3 index unchanged", d, 8'h05);
    bus_read(2'd1, d); chk("R3 data unchanged", d, 8'h3C);
    bus_read(2'd2, d); chk("R3 playback write ignored", d[1], 1'b0);

    // R4 sticky interrupt
    pulse_underflow();
    bus_read(2'd2, d); chk("R4 int set", d[0], 1'b1);
    bus_read(2'd2, d); chk("R4 int sticky", d[0], 1'b1);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, d); chk("R4 int cleared", d[0], 1'b0);

    // R5 request gating
    bus_write(2'd0, 8'h09); bus_write(2'd1, 8'h03);
    chk("R5 play_req on", play_req, 1'b1);
    chk("R5 cap_req idle", cap_req, 1'b0);
    chk("R5 dec on", cnt_dec_ok, 1'b1);
    pulse_underflow();
    chk("R5 no gate without trd", play_req, 1'b1);
    bus_write(2'd0, 8'h29);
    chk("R5 play_req gated", play_req, 1'b0);
    chk("R5 dec gated", cnt_dec_ok, 1'b0);
    bus_write(2'd2, 8'h5A);
    chk("R5 play_req resumed", play_req, 1'b1);
    chk("R5 dec resumed", cnt_dec_ok, 1'b1);
    bus_write(2'd0, 8'h09);

    // R6 stereo 16-bit capture order
    set_fmt(1'b1, 1'b1);
    pulse_cap(16'h1234, 16'hABCD);
    chk("R5 cap_req ready", cap_req, 1'b1);
    bus_read(2'd2, d); chk("R6 status first byte", d[7:5], 3'b011);
    bus_read(2'd3, d); chk("R6 byte0", d, 8'h34);
    bus_read(2'd3, d); chk("R6 byte1", d, 8'h12);
    bus_read(2'd2, d); chk("R6 status right lower", d[7:5], 3'b001);
    bus_read(2'd3, d); chk("R6 byte2", d, 8'hCD);
    bus_read(2'd3, d); chk("R6 byte3", d, 8'hAB);
    bus_read(2'd2, d); chk("R6 status done", d[7:5], 3'b100);
    bus_read(2'd3, d); chk("R6 hold last", d, 8'hAB);

    // R8 restart and R10 overrun
    pulse_cap(16'h5566, 16'h7788);
    bus_read(2'd2, d); chk("R10 no overrun", d[4], 1'b0);
    bus_read(2'd3, d); chk("R8 first of new", d, 8'h66);
    pulse_cap(16'h9900, 16'h1122);
    bus_read(2'd2, d); chk("R10 overrun flag", d[4], 1'b1);
    chk("R8 ready again", d[7:5], 3'b011);
    bus_read(2'd3, d); chk("R8 restart", d, 8'h00);

    // R11 long strobe acts once
    bus_read(2'd3, d, 30); chk("R11 long read", d, 8'h99);
    bus_read(2'd3, d); chk("R11 one advance", d, 8'h22);

    // R7 reduced formats
    set_fmt(1'b0, 1'b0);
    pulse_cap(16'hC3A1, 16'hFFFF);
    bus_read(2'd3, d); chk("R7 mono8 byte", d, 8'hC3);
    bus_read(2'd2, d); chk("R7 mono8 done, upper", {d[7], d[5]}, 2'b10);
    set_fmt(1'b1, 1'b0);
    pulse_cap(16'h4411, 16'h8822);
    bus_read(2'd2, d); chk("R7 stereo8 upper flag", d[7], 1'b1);
    bus_read(2'd3, d); chk("R7 stereo8 left", d, 8'h44);
    bus_read(2'd2, d); chk("R7 stereo8 right upper", d[7:6], 2'b10);
    bus_read(2'd3, d); chk("R7 stereo8 right", d, 8'h88);
    set_fmt(1'b0, 1'b1);
    pulse_cap(16'hBEEF, 16'h0000);
    bus_read(2'd3, d); chk("R7 mono16 lo", d, 8'hEF);
    bus_read(2'd3, d); chk("R7 mono16 hi", d, 8'hBE);
    bus_read(2'd2, d); chk("R7 mono16 done", d[5], 1'b0);

    // R9 playback assembly
    set_fmt(1'b1, 1'b1);
    pulse_take();
    bus_write(2'd3, 8'h11); bus_write(2'd3, 8'h22);
    bus_read(2'd2, d); chk("R9 play right lower next", d[3:1], 3'b000);
    bus_write(2'd3, 8'h33); bus_write(2'd3, 8'h44);
    bus_read(2'd2, d); chk("R9 full", d[1], 1'b1);
    chk("R5 play_req off when full", play_req, 1'b0);
    bus_write(2'd3, 8'h99);
    pulse_take();
    chk("R9 left word", play_left, 16'h2211);
    chk("R9 right word", play_right, 16'h4433);
    bus_read(2'd2, d); chk("R10 no underrun", d[4], 1'b0);
    set_fmt(1'b1, 1'b0);
    pulse_take();
    bus_write(2'd3, 8'hAA); bus_write(2'd3, 8'hBB);
    pulse_take();
    chk("R9 stereo8 left", play_left, 16'hAA00);
    chk("R9 stereo8 right", play_right, 16'hBB00);
    set_fmt(1'b0, 1'b0);
    pulse_take();
    bus_write(2'd3, 8'hCC);
    pulse_take();
    chk("R9 mono8 left", play_left, 16'hCC00);
    chk("R9 mono8 right", play_right, 16'hCC00);

    // R10 underrun
    pulse_take();
    chk("R10 underrun left", play_left, 16'h0000);
    chk("R10 underrun right", play_right, 16'h0000);
    bus_read(2'd2, d); chk("R10 underrun flag", d[4], 1'b1);

    // random capture traffic in random formats (R6, R7)
    for (int it = 0; it < 24; it++) begin
      logic st, wd;
      logic [15:0] l, r;
      st = 1'($urandom); wd = 1'($urandom);
      l = 16'($urandom); r = 16'($urandom);
      set_fmt(st, wd);
      pulse_cap(l, r);
      for (int k = 0; k < slot_count(st, wd); k++) begin
        bus_read(2'd3, d);
        chk("R6 random capture byte", d, byte_of(l, r, slot_at(st, wd, k)));
      end
      bus_read(2'd2, d); chk("R7 random capture done", d[5], 1'b0);
    end

    // random indirect register traffic (R1)
    for (int i = 0; i < 16; i++) mvalid[i] = 0;
    for (int it = 0; it < 40; it++) begin
      logic [3:0] ix;
      ix = 4'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0 || !mvalid[ix]) begin
        model[ix] = 8'($urandom);
        mvalid[ix] = 1;
        bus_write(2'd0, {4'h0, ix});
        bus_write(2'd1, model[ix]);
      end else begin
        bus_write(2'd0, {4'h0, ix});
        bus_read(2'd1, d);
        chk("R1 random indirect", d, model[ix]);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule